// File: doc/BRIEF.md
# Snooped Cache Enable Bit

This block listens on a 32-bit processor bus for a write to one register location that belongs to another peripheral in the I/O space. When that write completes, it copies data bit 0 into a one-bit flag. The flag is the cache enable level handed to the cache tag logic, and it can also be routed to a debug pin. The block never drives the data bus and never acknowledges the cycle. It only observes the cycle that the owning peripheral completes.

The address compare uses a sparse mask. The top nibble must select the I/O space, and a handful of middle and low bits are fixed. Every other bit is a don't-care, so the whole 256-byte window at offsets 0x1F00..0x1FFF of each matching region is aliased onto the bit. Software turns the cache on or off at run time with a read-modify-write of bit 0. The new level takes effect on the next clock, and no reset is needed. The flag loads at most once per address-strobe period.

Top module: `cache_en_snoop`

## Requirements
- R1: While rst_ni is low, cache_en_o is 0. The clear acts asynchronously, without waiting for a clock edge.
- R2: An address matches only when bits 31..28 equal 4'b0101, bits 11..8 are all 1, and bits 17, 16, 14 and 13 are all 0. A write to any other address leaves cache_en_o unchanged.
- R3: Address bits outside the set named in R2 do not affect the match. Both 0x50F01F03 and 0x5AB89F55 load the flag.
- R4: The flag loads only on a clock where as_n_i=0, rd_wr_i=0 (write), ack_n_i=0 and the address matches. If any one of these is missing, nothing is loaded.
- R5: On every clock without a load, cache_en_o keeps its value.
- R6: A qualifying write with data0_i=1 sets cache_en_o, and one with data0_i=0 clears it. Both directions work live, with no reset in between.
- R7: Only the first qualifying clock of an address-strobe period loads the flag. Later clocks of the same period change nothing, even if data0_i changes.
- R8: A read (rd_wr_i=1) of the matching address leaves cache_en_o unchanged.
- R9: cache_en_o is a register output. It shows the loaded value from the clock edge that sampled the qualifying inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; all inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| addr_i | input | 32 | Processor address bus |
| data0_i | input | 1 | Data bus bit 0 |
| as_n_i | input | 1 | Address strobe, active low |
| rd_wr_i | input | 1 | Transfer direction: 1 read, 0 write |
| ack_n_i | input | 1 | Low-order data-size acknowledge, active low |
| cache_en_o | output | 1 | Registered cache enable level, also usable as a debug pin |

## Verification
The bench sends matching writes of 1 and of 0 back to back, which tells a live toggle apart from a flag that sticks. It also sends matching reads and writes that lack the strobe or the acknowledge, which separates a full load qualifier from a partial one. Several addresses each break exactly one constrained bit, and one address flips many don't-care bits. Together these show whether the mask is too loose or too tight. One write changes its data bit while the acknowledge is held, which separates a once-per-cycle load from a level-sensitive one. A reset in the middle of the run shows that the clear is asynchronous.

// File: rtl/cen_pkg.sv
package cen_pkg;
  localparam int unsigned ADDR_W = 32;
  // constrained bits: 31..28, 17, 16, 14, 13, 11..8
  localparam logic [ADDR_W-1:0] HIT_MASK = 32'hF003_6F00;
  localparam logic [ADDR_W-1:0] HIT_VAL  = 32'h5000_0F00;
endpackage

// File: rtl/cen_addr_match.sv
module cen_addr_match #(
  parameter int unsigned W = cen_pkg::ADDR_W,
  parameter logic [W-1:0] MASK = cen_pkg::HIT_MASK,
  parameter logic [W-1:0] VAL  = cen_pkg::HIT_VAL
) (
  input  logic [W-1:0] addr_i,
  output logic         hit_o
);
  localparam logic [W-1:0] VAL_M = VAL & MASK;
  assign hit_o = ((addr_i & MASK) == VAL_M);
endmodule

// File: rtl/cen_cycle_gate.sv
module cen_cycle_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_n_i,
  input  logic rd_wr_i,
  input  logic ack_n_i,
  input  logic hit_i,
  output logic load_o
);
  logic done_q;

  // one load per strobe period
  assign load_o = !as_n_i && !rd_wr_i && !ack_n_i && hit_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (as_n_i) done_q <= 1'b0;
    else if (load_o) done_q <= 1'b1;
  end
endmodule

// File: rtl/cen_flag.sv
module cen_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cache_en_snoop.sv
module cache_en_snoop #(
  parameter int unsigned ADDR_W = cen_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] MATCH_MASK = cen_pkg::HIT_MASK,
  parameter logic [ADDR_W-1:0] MATCH_VAL  = cen_pkg::HIT_VAL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data0_i,
  input  logic              as_n_i,
  input  logic              rd_wr_i,
  input  logic              ack_n_i,
  output logic              cache_en_o
);
  logic hit;
  logic load;

  cen_addr_match #(.W(ADDR_W), .MASK(MATCH_MASK), .VAL(MATCH_VAL)) u_match (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  cen_cycle_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .as_n_i  (as_n_i),
    .rd_wr_i (rd_wr_i),
    .ack_n_i (ack_n_i),
    .hit_i   (hit),
    .load_o  (load)
  );

  cen_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (data0_i),
    .q_o    (cache_en_o)
  );
endmodule

// File: rtl/cache_en_snoop_chk.sv
module cache_en_snoop_chk #(
  parameter int unsigned ADDR_W = cen_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] MATCH_MASK = cen_pkg::HIT_MASK,
  parameter logic [ADDR_W-1:0] MATCH_VAL  = cen_pkg::HIT_VAL
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data0_i,
  input logic              as_n_i,
  input logic              rd_wr_i,
  input logic              ack_n_i,
  input logic              cache_en_o
);
  logic wr_full;
  assign wr_full = !as_n_i && !rd_wr_i && !ack_n_i
                   && ((addr_i & MATCH_MASK) == (MATCH_VAL & MATCH_MASK));

  // R1: reset holds the flag clear
  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (cache_en_o == 1'b0);

  // R5: any change needs a qualifying write on the prior edge
  assert_change_needs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cache_en_o) |-> $past(wr_full));

  // R8: reads never alter the flag
  assert_read_no_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_i && rd_wr_i) |=> $stable(cache_en_o));

  // R6/R9: first qualifying clock of a strobe period loads bit 0
  assert_first_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(as_n_i) && wr_full) |=> (cache_en_o == $past(data0_i)));

  // R7: later clocks of the same strobe period load nothing
  assert_single_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !as_n_i && $past(wr_full)) |=> $stable(cache_en_o));
endmodule

bind cache_en_snoop cache_en_snoop_chk #(
  .ADDR_W(ADDR_W), .MATCH_MASK(MATCH_MASK), .MATCH_VAL(MATCH_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .data0_i    (data0_i),
  .as_n_i     (as_n_i),
  .rd_wr_i    (rd_wr_i),
  .ack_n_i    (ack_n_i),
  .cache_en_o (cache_en_o)
);

// File: tb/tb_cache_en_snoop.sv
`timescale 1ns/1ps
module tb_cache_en_snoop;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        data0_i = 1'b0;
  logic        as_n_i = 1'b1;
  logic        rd_wr_i = 1'b1;
  logic        ack_n_i = 1'b1;
  logic        cache_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  cache_en_snoop dut (.*);

  // behavioural reference: window test written as explicit bit checks
  bit ref_en = 0;
  bit ref_taken = 0;
  function automatic bit addr_ok(input logic [31:0] a);
    return a[31:28] == 4'd5 && a[11] && a[10] && a[9] && a[8]
           && !a[17] && !a[16] && !a[14] && !a[13];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_en = 0; ref_taken = 0;
    end else if (as_n_i) begin
      ref_taken = 0;
    end else if (!ref_taken && !rd_wr_i && !ack_n_i && addr_ok(addr_i)) begin
      ref_en = data0_i; ref_taken = 1;
    end
  end

  // R9: compared on every clock, away from the active edge
  always @(negedge clk_i) if (!finished) begin
    total++;
    if (cache_en_o !== ref_en) begin
      bad++;
      $display("FAIL R9 cycle compare: act=%b exp=%b t=%0t", cache_en_o, ref_en, $time);
    end
  end

  task automatic chk(input logic exp, input string req);
    total++;
    if (cache_en_o !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, cache_en_o, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] a, input logic d, input logic rd,
                     input logic use_as, input logic use_ack, input int hold);
    @(negedge clk_i);
    addr_i = a; data0_i = d; rd_wr_i = rd; as_n_i = !use_as;
    @(negedge clk_i);
    ack_n_i = !use_ack;
    for (int i = 0; i < hold; i++) @(negedge clk_i);
    as_n_i = 1'b1; ack_n_i = 1'b1; rd_wr_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #3;
    chk(1'b0, "R1 reset value");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1'b0, "R1 after release");

    cyc(32'h50F0_1F03, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R6 write 1 enables");
    cyc(32'h50F0_1F03, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b0, "R6 write 0 disables live");
    cyc(32'h5AB8_9F55, 1'b1, 1'b0, 1'b1, 1'b1, 2);
    chk(1'b1, "R3 don't-care bits flipped");

    cyc(32'h40F0_1F03, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R2 top nibble wrong");
    cyc(32'h50F0_1E03, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R2 bit 8 low");
    cyc(32'h50F0_3F03, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R2 bit 13 high");
    cyc(32'h50F1_1F03, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R2 bit 16 high");

    cyc(32'h50F0_1F03, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    chk(1'b1, "R8 read of matching address");
    cyc(32'h50F0_1F03, 1'b0, 1'b0, 1'b1, 1'b0, 3);
    chk(1'b1, "R4 no acknowledge");
    cyc(32'h50F0_1F03, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    chk(1'b1, "R4 no address strobe");

    repeat (5) @(negedge clk_i);
    chk(1'b1, "R5 idle hold");

    // R7: data flips while acknowledge stays low
    @(negedge clk_i);
    addr_i = 32'h50F0_1F03; data0_i = 1'b0; rd_wr_i = 1'b0; as_n_i = 1'b0;
    @(negedge clk_i); ack_n_i = 1'b0;
    @(negedge clk_i);
    chk(1'b0, "R9 loaded one edge after sampling");
    data0_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk(1'b0, "R7 second clock of same cycle ignored");
    as_n_i = 1'b1; ack_n_i = 1'b1; rd_wr_i = 1'b1;
    @(negedge clk_i);

    cyc(32'h50F0_1F03, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    chk(1'b1, "R6 re-enable");
    #1 rst_ni = 1'b0;
    #0.5;
    chk(1'b0, "R1 asynchronous clear");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1'b0, "R1 stays clear after release");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    finished = 1;
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule